// File: doc/BRIEF.md
# Test-port pulse and status data registers

This block supplies the device-specific data registers that sit behind a test access port instruction decoder. It takes the decoded controller state flags and the instruction register contents from an external TAP controller. From these it forms the scan path between the serial data input and output, and drives a few board-level pins from what is scanned.

Two single-bit registers turn a data scan into a timed event. One gives a low pulse, one test clock long, on a board self-test pin. The other gives the same pulse on every local scan port reset line at once. The port-reset pulse leaves the rest of the block's configuration untouched, so the child chains can be reset without deselecting the device. An 8-bit register samples external status pins without disturbing the board. A 6-bit register gates one write-strobe driver per local port. The identification, user code and bypass registers complete the set. The TAP state machine and the routing of the local chains are handled elsewhere.

Top module: `tap_aux_regs`

## Requirements
- R1: While reset is asserted and after it is released, `self_test_n` and every bit of `port_trst_n` are high and `strobe_oe` is all zeros.
- R2: With instruction 0x99 loaded, a data scan whose single bit is still 0 at Update-DR drives `self_test_n` low. The low starts at the falling clock edge inside the Update-DR cycle and lasts exactly one test clock period.
- R3: With instruction 0x9B loaded, the same kind of scan drives all six `port_trst_n` bits low together for exactly one test clock period starting in Update-DR. `strobe_oe` keeps its value.
- R4: The 1-bit register of instructions 0x99 and 0x9B loads 0 on Capture-DR, so `tdo` reads 0 in the first shift cycle. If a 1 is shifted in before Update-DR, no pulse is produced.
- R5: Under any instruction other than 0x99, `self_test_n` stays high through Update-DR. Under any instruction other than 0x9B, `port_trst_n` stays all ones. The two pulses never overlap.
- R6: Instruction 0x9A selects an 8-bit register that samples `status_in` on Capture-DR and shifts it out LSB first. Changes on `status_in` during shifting do not alter the bits shifted out.
- R7: Instruction 0x98 selects a 6-bit register shifted LSB first, with `tdi` entering at bit 5. On Update-DR its contents move to `strobe_oe`, where bit k set to 1 enables port k's strobe driver and 0 leaves it in high impedance. Capture-DR loads the current `strobe_oe`. `strobe_oe` changes only on Update-DR under this instruction or on Test-Logic-Reset.
- R8: A cycle in Test-Logic-Reset (`tlr_st` high) clears `strobe_oe` to zero on the next rising edge.
- R9: Instruction 0xAA shifts out 0x0000836F LSB first. That value is loaded on Test-Logic-Reset, on Capture-IR and on Capture-DR under this instruction.
- R10: Instruction 0x97 selects a 32-bit register that reads back all zeros.
- R11: Instruction 0xFF and every opcode not listed above select a 1-bit bypass register. It captures 0 and delays `tdi` by one shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tlr_st | input | 1 | Controller is in Test-Logic-Reset |
| capture_ir | input | 1 | Controller is in Capture-IR |
| capture_dr | input | 1 | Controller is in Capture-DR |
| shift_dr | input | 1 | Controller is in Shift-DR |
| update_dr | input | 1 | Controller is in Update-DR |
| ir | input | 8 | Current instruction register contents |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out of the selected register |
| status_in | input | 8 | External board status pins |
| self_test_n | output | 1 | Active-low self-test pulse |
| port_trst_n | output | 6 | Active-low reset pulse to each local port |
| strobe_oe | output | 6 | Per-port write-strobe driver enable |

## Verification
On every cycle, assertions check three things about the pulses. A low on either pulse output only appears while Update-DR is asserted, never lasts past one falling edge, and never coincides with the other pulse. They also check that `strobe_oe` moves only on Update-DR or Test-Logic-Reset, that Test-Logic-Reset clears it, and that a port-reset pulse leaves it untouched. The scenarios go further. They sweep all 256 opcodes to show which ones pulse, all 256 status values and all 64 strobe settings with their readback, and the identification, user code and bypass contents. They also cover pulse suppression by a shifted 1 and status changes in mid-scan. None of these can be seen from a single cycle.

// File: rtl/tap_aux_pkg.sv
package tap_aux_pkg;

  localparam int IR_W = 8;

  localparam logic [IR_W-1:0] OP_STROBE   = 8'h98;
  localparam logic [IR_W-1:0] OP_SELFTEST = 8'h99;
  localparam logic [IR_W-1:0] OP_STATUS   = 8'h9A;
  localparam logic [IR_W-1:0] OP_PRST     = 8'h9B;
  localparam logic [IR_W-1:0] OP_IDCODE   = 8'hAA;
  localparam logic [IR_W-1:0] OP_USER     = 8'h97;

  typedef enum logic [2:0] {
    DR_BYPASS,
    DR_IDCODE,
    DR_USER,
    DR_STATUS,
    DR_STROBE,
    DR_SELFTEST,
    DR_PRST
  } dr_sel_e;

endpackage

// File: rtl/tap_aux_decode.sv
module tap_aux_decode
  import tap_aux_pkg::*;
(
  input  logic [IR_W-1:0] ir,
  output dr_sel_e         sel
);

  always_comb begin
    case (ir)
      OP_STROBE:   sel = DR_STROBE;
      OP_SELFTEST: sel = DR_SELFTEST;
      OP_STATUS:   sel = DR_STATUS;
      OP_PRST:     sel = DR_PRST;
      OP_IDCODE:   sel = DR_IDCODE;
      OP_USER:     sel = DR_USER;
      default:     sel = DR_BYPASS;
    endcase
  end

endmodule

// File: rtl/tap_aux_shreg.sv
module tap_aux_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  input  logic         shift_en,
  input  logic         sin,
  output logic [W-1:0] q
);

  logic [W-1:0] q_d;

  generate
    if (W == 1) begin : g_single
      always_comb begin
        q_d = q;
        if (load_en)       q_d = load_val;
        else if (shift_en) q_d = sin;
      end
    end else begin : g_multi
      always_comb begin
        q_d = q;
        if (load_en)       q_d = load_val;
        else if (shift_en) q_d = {sin, q[W-1:1]};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end

endmodule

// File: rtl/tap_aux_pulse.sv
module tap_aux_pulse #(
  parameter int N = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fire,
  output logic [N-1:0] pulse_n
);

  genvar k;
  generate
    for (k = 0; k < N; k++) begin : g_bit
      logic d;
      always_comb d = ~fire;
      always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) pulse_n[k] <= 1'b1;
        else        pulse_n[k] <= d;
      end

      // R2
      one_tck_low_chk: assert property (@(negedge clk) disable iff (!rst_n)
        !pulse_n[k] |=> pulse_n[k]);
    end
  endgenerate

endmodule

// File: rtl/tap_aux_regs.sv
module tap_aux_regs
  import tap_aux_pkg::*;
#(
  parameter int          NPORTS     = 6,
  parameter int          STAT_W     = 8,
  parameter int          ID_W       = 32,
  parameter int          USER_W     = 32,
  parameter logic [31:0] IDCODE_VAL = 32'h0000_836F
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tlr_st,
  input  logic              capture_ir,
  input  logic              capture_dr,
  input  logic              shift_dr,
  input  logic              update_dr,
  input  logic [IR_W-1:0]   ir,
  input  logic              tdi,
  output logic              tdo,
  input  logic [STAT_W-1:0] status_in,
  output logic              self_test_n,
  output logic [NPORTS-1:0] port_trst_n,
  output logic [NPORTS-1:0] strobe_oe
);

  localparam logic [ID_W-1:0] ID_LOAD = ID_W'(IDCODE_VAL);

  // reset: asserted asynchronously, released on a rising edge
  logic [1:0] rst_sync;
  logic       rst_n;
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) rst_sync <= 2'b00;
    else         rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n = rst_sync[1];

  dr_sel_e sel;
  tap_aux_decode u_dec (.ir(ir), .sel(sel));

  logic cap_byp, cap_id, cap_usr, cap_st, cap_sb, cap_pb;
  logic sh_byp, sh_id, sh_usr, sh_st, sh_sb, sh_pb;
  always_comb begin
    cap_byp = capture_dr && (sel == DR_BYPASS);
    cap_id  = tlr_st || capture_ir || (capture_dr && (sel == DR_IDCODE));
    cap_usr = capture_dr && (sel == DR_USER);
    cap_st  = capture_dr && (sel == DR_STATUS);
    cap_sb  = capture_dr && (sel == DR_STROBE);
    cap_pb  = capture_dr && ((sel == DR_SELFTEST) || (sel == DR_PRST));
    sh_byp  = shift_dr && (sel == DR_BYPASS);
    sh_id   = shift_dr && (sel == DR_IDCODE) && !cap_id;
    sh_usr  = shift_dr && (sel == DR_USER);
    sh_st   = shift_dr && (sel == DR_STATUS);
    sh_sb   = shift_dr && (sel == DR_STROBE);
    sh_pb   = shift_dr && ((sel == DR_SELFTEST) || (sel == DR_PRST));
  end

  logic [0:0]        byp_q, pb_q;
  logic [ID_W-1:0]   id_q;
  logic [USER_W-1:0] usr_q;
  logic [STAT_W-1:0] st_q;
  logic [NPORTS-1:0] sb_q;

  tap_aux_shreg #(.W(1)) u_byp (.clk(tck), .rst_n(rst_n), .load_en(cap_byp),
    .load_val(1'b0), .shift_en(sh_byp), .sin(tdi), .q(byp_q));
  tap_aux_shreg #(.W(ID_W)) u_id (.clk(tck), .rst_n(rst_n), .load_en(cap_id),
    .load_val(ID_LOAD), .shift_en(sh_id), .sin(tdi), .q(id_q));
  tap_aux_shreg #(.W(USER_W)) u_usr (.clk(tck), .rst_n(rst_n), .load_en(cap_usr),
    .load_val('0), .shift_en(sh_usr), .sin(tdi), .q(usr_q));
  tap_aux_shreg #(.W(STAT_W)) u_st (.clk(tck), .rst_n(rst_n), .load_en(cap_st),
    .load_val(status_in), .shift_en(sh_st), .sin(tdi), .q(st_q));
  tap_aux_shreg #(.W(NPORTS)) u_sb (.clk(tck), .rst_n(rst_n), .load_en(cap_sb),
    .load_val(strobe_oe), .shift_en(sh_sb), .sin(tdi), .q(sb_q));
  tap_aux_shreg #(.W(1)) u_pb (.clk(tck), .rst_n(rst_n), .load_en(cap_pb),
    .load_val(1'b0), .shift_en(sh_pb), .sin(tdi), .q(pb_q));

  // strobe enable holding register
  logic              sb_upd;
  logic [NPORTS-1:0] oe_d;
  always_comb begin
    sb_upd = update_dr && (sel == DR_STROBE);
    oe_d   = strobe_oe;
    if (tlr_st)      oe_d = '0;
    else if (sb_upd) oe_d = sb_q;
  end
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) strobe_oe <= '0;
    else        strobe_oe <= oe_d;
  end

  // R7
  strobe_hold_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (!update_dr && !tlr_st) |=> $stable(strobe_oe));
  // R8
  tlr_clear_chk: assert property (@(posedge tck) disable iff (!rst_n)
    tlr_st |=> (strobe_oe == '0));

  // pulse requests, registered on the falling edge
  logic st_fire, pr_fire;
  always_comb begin
    st_fire = update_dr && (sel == DR_SELFTEST) && !pb_q[0];
    pr_fire = update_dr && (sel == DR_PRST) && !pb_q[0];
  end

  logic [0:0] st_pulse;
  tap_aux_pulse #(.N(1)) u_stp (.clk(tck), .rst_n(rst_n), .fire(st_fire),
    .pulse_n(st_pulse));
  tap_aux_pulse #(.N(NPORTS)) u_prp (.clk(tck), .rst_n(rst_n), .fire(pr_fire),
    .pulse_n(port_trst_n));
  assign self_test_n = st_pulse[0];

  // R2
  selftest_in_update_chk: assert property (@(posedge tck) disable iff (!rst_n)
    !self_test_n |-> update_dr);
  // R3
  prst_in_update_chk: assert property (@(posedge tck) disable iff (!rst_n)
    !port_trst_n[0] |-> update_dr);
  // R3
  prst_keeps_cfg_chk: assert property (@(posedge tck) disable iff (!rst_n)
    !port_trst_n[0] |=> $stable(strobe_oe));
  // R5
  pulse_excl_chk: assert property (@(posedge tck) disable iff (!rst_n)
    !self_test_n |-> (port_trst_n == '1));

  always_comb begin
    case (sel)
      DR_IDCODE:   tdo = id_q[0];
      DR_USER:     tdo = usr_q[0];
      DR_STATUS:   tdo = st_q[0];
      DR_STROBE:   tdo = sb_q[0];
      DR_SELFTEST: tdo = pb_q[0];
      DR_PRST:     tdo = pb_q[0];
      default:     tdo = byp_q[0];
    endcase
  end

endmodule

// File: tb/test_tap_aux_regs.sv
`timescale 1ns/1ps
module test_tap_aux_regs;

  logic       tck = 1'b0;
  logic       trst_n;
  logic       tlr_st, capture_ir, capture_dr, shift_dr, update_dr;
  logic [7:0] ir;
  logic       tdi;
  logic       tdo;
  logic [7:0] status_in;
  logic       self_test_n;
  logic [5:0] port_trst_n;
  logic [5:0] strobe_oe;

  tap_aux_regs i_tap_aux_regs (
    .tck(tck), .trst_n(trst_n), .tlr_st(tlr_st), .capture_ir(capture_ir),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
    .ir(ir), .tdi(tdi), .tdo(tdo), .status_in(status_in),
    .self_test_n(self_test_n), .port_trst_n(port_trst_n), .strobe_oe(strobe_oe)
  );

  always #4 tck = ~tck;

  int checks = 0;
  int errors = 0;
  bit reported = 0;

  logic       s_tdo, s_st;
  logic [5:0] s_pt, s_so;

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
    end
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one controller cycle: drive just after the rising edge, sample just before the next
  task automatic cyc(input logic c, input logic s, input logic u, input logic t,
                     input logic ci, input logic d);
    capture_dr = c; shift_dr = s; update_dr = u; tlr_st = t; capture_ir = ci; tdi = d;
    #6;
    s_tdo = tdo; s_st = self_test_n; s_pt = port_trst_n; s_so = strobe_oe;
    @(posedge tck); #1;
  endtask

  task automatic dr_scan(input int n, input logic [31:0] din, input int chg_i,
                         input logic [7:0] chg_v, output logic [31:0] dout,
                         output logic st_up, output logic [5:0] pt_up,
                         output logic st_af, output logic [5:0] pt_af,
                         output logic [5:0] so_af);
    dout = '0;
    cyc(1, 0, 0, 0, 0, 0);
    for (int i = 0; i < n; i++) begin
      if (i == chg_i) status_in = chg_v;
      cyc(0, 1, 0, 0, 0, din[i]);
      dout[i] = s_tdo;
    end
    cyc(0, 0, 1, 0, 0, 0);
    st_up = s_st; pt_up = s_pt;
    cyc(0, 0, 0, 0, 0, 0);
    st_af = s_st; pt_af = s_pt; so_af = s_so;
  endtask

  initial begin
    #(8 * 190000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    logic [31:0] dout;
    logic        st_up, st_af;
    logic [5:0]  pt_up, pt_af, so_af;
    logic [5:0]  cur_oe;

    trst_n = 0; tlr_st = 0; capture_ir = 0; capture_dr = 0; shift_dr = 0;
    update_dr = 0; ir = 8'hFF; tdi = 0; status_in = 8'h00;
    repeat (3) @(posedge tck);
    #1;
    chk(self_test_n === 1'b1 && port_trst_n === 6'h3F && strobe_oe === 6'h00,
        "R1 during reset", {self_test_n, port_trst_n, strobe_oe}, 32'h1FC0);
    trst_n = 1;
    repeat (3) cyc(0, 0, 0, 0, 0, 0);
    chk(s_st === 1'b1 && s_pt === 6'h3F && s_so === 6'h00,
        "R1 after release", {s_st, s_pt, s_so}, 32'h1FC0);

    // R9 identification
    ir = 8'hAA;
    dr_scan(32, 32'h0, -1, 0, dout, st_up, pt_up, st_af, pt_af, so_af);
    chk(dout === 32'h0000836F, "R9 idcode", dout, 32'h0000836F);
    cyc(0, 0, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 0, 0);
    dr_scan(32, 32'hFFFF_FFFF, -1, 0, dout, st_up, pt_up, st_af, pt_af, so_af);
    chk(dout === 32'h0000836F, "R9 idcode rescan", dout, 32'h0000836F);

    // R10 user code
    ir = 8'h97;
    dr_scan(32, 32'hA5A5_5A5A, -1, 0, dout, st_up, pt_up, st_af, pt_af, so_af);
    chk(dout === 32'h0, "R10 user zeros", dout, 32'h0);

    // R11 bypass on several undefined opcodes
    foreach (ir[i]) begin end
    for (int k = 0; k < 4; k++) begin
      logic [7:0] op;
      op = (k == 0) ? 8'hFF : (k == 1) ? 8'h00 : (k == 2) ? 8'h55 : 8'h9C;
      ir = op;
      dr_scan(5, 32'b01101, -1, 0, dout, st_up, pt_up, st_af, pt_af, so_af);
      chk(dout[4:0] === 5'b11010, "R11 bypass delay", dout[4:0], 5'b11010);
    end

    // R7 sweep strobe settings with readback of the previous value
    ir = 8'h98;
    cur_oe = 6'h00;
    for (int v = 0; v < 64; v++) begin
      dr_scan(6, v, -1, 0, dout, st_up, pt_up, st_af, pt_af, so_af);
      chk(so_af === v[5:0], "R7 strobe update", so_af, v);
      chk(dout[5:0] === cur_oe, "R7 strobe readback", dout[5:0], cur_oe);
      cur_oe = v[5:0];
    end

    // R8 test-logic-reset clears strobe enables
    dr_scan(6, 32'h2D, -1, 0, dout, st_up, pt_up, st_af, pt_af, so_af);
    cyc(0, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 0, 0, 0);
    chk(s_so === 6'h00, "R8 tlr clear", s_so, 0);
    dr_scan(6, 32'h2D, -1, 0, dout, st_up, pt_up, st_af, pt_af, so_af);
    cur_oe = 6'h2D;

    // R6 status sweep
    ir = 8'h9A;
    for (int v = 0; v < 256; v++) begin
      status_in = v[7:0];
      dr_scan(8, 32'h0, -1, 0, dout, st_up, pt_up, st_af, pt_af, so_af);
      chk(dout[7:0] === v[7:0], "R6 status capture", dout[7:0], v);
    end
    status_in = 8'hC3;
    dr_scan(8, 32'h0, 2, 8'h3C, dout, st_up, pt_up, st_af, pt_af, so_af);
    chk(dout[7:0] === 8'hC3, "R6 status change mid-shift", dout[7:0], 8'hC3);

    // R2 and R4 self-test pulse and capture
    ir = 8'h99;
    dr_scan(1, 32'h0, -1, 0, dout, st_up, pt_up, st_af, pt_af, so_af);
    chk(dout[0] === 1'b0, "R4 captured zero", dout[0], 0);
    chk(st_up === 1'b0, "R2 low in update", st_up, 0);
    chk(st_af === 1'b1, "R2 high next cycle", st_af, 1);
    dr_scan(1, 32'h1, -1, 0, dout, st_up, pt_up, st_af, pt_af, so_af);
    chk(st_up === 1'b1 && st_af === 1'b1, "R4 suppressed by one", {st_up, st_af}, 2'b11);

    // R3 port reset pulse keeps strobe setting
    ir = 8'h9B;
    dr_scan(1, 32'h0, -1, 0, dout, st_up, pt_up, st_af, pt_af, so_af);
    chk(pt_up === 6'h00, "R3 all low in update", pt_up, 0);
    chk(pt_af === 6'h3F, "R3 high next cycle", pt_af, 6'h3F);
    chk(so_af === cur_oe, "R3 strobe kept", so_af, cur_oe);
    dr_scan(1, 32'h1, -1, 0, dout, st_up, pt_up, st_af, pt_af, so_af);
    chk(pt_up === 6'h3F, "R4 port reset suppressed", pt_up, 6'h3F);

    // R5 opcode sweep: only the two pulse opcodes pulse
    for (int op = 0; op < 256; op++) begin
      logic exp_st, exp_pt;
      ir = op[7:0];
      exp_st = (op == 8'h99) ? 1'b0 : 1'b1;
      exp_pt = (op == 8'h9B) ? 1'b0 : 1'b1;
      dr_scan(1, 32'h0, -1, 0, dout, st_up, pt_up, st_af, pt_af, so_af);
      chk(st_up === exp_st, "R5 self-test by opcode", {op[7:0], st_up}, {op[7:0], exp_st});
      chk(pt_up === {6{exp_pt}}, "R5 port reset by opcode", {op[7:0], pt_up},
          {op[7:0], {6{exp_pt}}});
      if (op == 8'h98) cur_oe = {1'b0, cur_oe[5:1]};
      chk(so_af === cur_oe, "R7 strobe only on its update", so_af, cur_oe);
    end

    report();
    $finish;
  end

endmodule